// File: doc/BRIEF.md
# Packet Command Parser Front-End

This block is the framing and status stage of a vector-interface command processor. An input FIFO presents whole 128-bit packets. The block reads one 32-bit word from the current packet per cycle and pops the packet once its last word has been used. When the block is idle, the next word is taken as a command. The command tells the block how many data words follow. Each of those words is passed downstream with a one-cycle valid strobe. Unpacking and the memory write path come after this block.

The block owns a 2-bit phase status, a stop stall flag, a command error flag and a sticky interrupt flag. A small control write port carries three write-to-act bits: reset, stop and stall cancel. Reset and stop stay pending until the block is idle and not stalled. Stall cancel acts in the cycle it is written. When a command with its interrupt bit set completes, a one-cycle interrupt pulse is raised.

Top module: `pkt_cmd_parser`

## Requirements
- R1: After reset, `phase` is 2'b00 and `stop_stall`, `cmd_err`, `irq_seen`, `out_valid`, `irq`, `in_pop` and `in_flush` are all 0. `phase` encodes 00 idle, 01 waiting for data, 10 decoding a command and 11 transferring data.
- R2: A packet holds four words, with word 0 in bits 31:0 and word 3 in bits 127:96. One word is consumed per productive cycle. `in_pop` is high in the cycle that consumes word 3, and the next word used is word 0 of the next packet. The word position is kept across commands and stalls.
- R3: No word is consumed while `in_valid` is low, so a partly filled packet is never used. If data words are still owed and no packet is present, `phase` shows 01.
- R4: In idle, the current word is taken as a command. Bit 31 is the interrupt request and bits 30:24 are the opcode: 0 means no data, 1 means data. For opcode 1, bits 23:16 give the word count, and a count of 0 means 256. After the fetch edge, `phase` is 10 for exactly one cycle. It then becomes 11 if words are owed, or 00 if none are.
- R5: Each data word is presented on `out_data` with `out_valid` high for one cycle, in the cycle after the edge that consumed it. Words arrive in input order. After the last word, `phase` returns to 00.
- R6: When a command completes and its bit 31 is set, `irq` pulses for one cycle in the cycle where `phase` has just returned to 00, and `irq_seen` is set. A command with bit 31 clear produces no pulse.
- R7: An opcode other than 0 or 1 sets `cmd_err`, keeps `phase` at 00 and drops the word, including its interrupt bit. A valid command clears `cmd_err`.
- R8: While `stop_stall` or `cmd_err` is set, no word is consumed and no pending request is honoured.
- R9: Writing control bit 2 (stall cancel) clears `stop_stall`, `cmd_err` and `irq_seen`. The stall test in that same cycle already uses the cleared flags, so a waiting command is fetched in that cycle.
- R10: Writing control bit 1 (stop) leaves a request pending until the block is idle and not stalled. The request then sets `stop_stall` and clears itself. It takes priority over a pending reset and over a fetch.
- R11: Writing control bit 0 (reset) leaves a request pending until the block is idle and not stalled. The request then pulses `in_flush` for one cycle and returns position, counters and flags to their power-on values, so the next packet is parsed from word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A complete packet is present at the FIFO head |
| in_data | input | 128 | Packet at the FIFO head |
| in_pop | output | 1 | Remove the head packet at this edge |
| in_flush | output | 1 | Empty the input FIFO at this edge |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Bit 0 reset, bit 1 stop, bit 2 stall cancel |
| phase | output | 2 | Processing phase status |
| stop_stall | output | 1 | Stalled by a stop request |
| cmd_err | output | 1 | Stalled by an unrecognised command |
| irq_seen | output | 1 | Sticky record of a raised interrupt |
| out_valid | output | 1 | Data word strobe |
| out_data | output | 32 | Data word |
| irq | output | 1 | Command completion interrupt pulse |

## Verification
The stall cancel write and the command fetch can fall in the same cycle, because the cancel is applied before the stall test. The bench provokes this by parking the block on `cmd_err` while a valid command waits in the FIFO, and then issuing the cancel. On the very next sample, `cmd_err` must be clear and `phase` must already read 10. A second collision, a stop request arriving mid-transfer, is judged by `stop_stall` staying low until the transfer has returned the block to idle.

// File: rtl/pkt_cmd_parser.sv
module pkt_cmd_parser #(
  parameter int WORD_W    = 32,
  parameter int PKT_WORDS = 4,
  parameter int IRQ_BIT   = 31,
  parameter int OP_LSB    = 24,
  parameter int OP_W      = 7,
  parameter int NUM_LSB   = 16,
  parameter int NUM_W     = 8
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [WORD_W*PKT_WORDS-1:0] in_data,
  output logic                        in_pop,
  output logic                        in_flush,
  input  logic                        ctl_wr,
  input  logic [2:0]                  ctl_wdata,
  output logic [1:0]                  phase,
  output logic                        stop_stall,
  output logic                        cmd_err,
  output logic                        irq_seen,
  output logic                        out_valid,
  output logic [WORD_W-1:0]           out_data,
  output logic                        irq
);

  localparam int POS_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;
  localparam int CNT_W = NUM_W + 1;
  localparam logic [1:0] PH_IDLE = 2'b00;
  localparam logic [1:0] PH_WAIT = 2'b01;
  localparam logic [1:0] PH_DEC  = 2'b10;
  localparam logic [1:0] PH_XFER = 2'b11;
  localparam int CTL_RST = 0;
  localparam int CTL_STOP = 1;
  localparam int CTL_CANCEL = 2;
  localparam logic [OP_W-1:0] OP_NOP  = '0;
  localparam logic [OP_W-1:0] OP_DATA = OP_W'(1);

  logic [POS_W-1:0]  pos;
  logic [CNT_W-1:0]  left;
  logic              irq_en, stp_req, rst_req;
  logic [WORD_W-1:0] cur_word;
  logic [OP_W-1:0]   op;
  logic [NUM_W-1:0]  num_f;
  logic [CNT_W-1:0]  load_cnt;
  logic              cmd_ok, cancel, stalled, idle, data_ph;
  logic              do_stop, do_rst, do_fetch, do_data, consume, last_pos;

  assign cur_word = in_data[int'(pos)*WORD_W +: WORD_W];
  assign op       = cur_word[OP_LSB +: OP_W];
  assign num_f    = cur_word[NUM_LSB +: NUM_W];
  assign cmd_ok   = (op == OP_NOP) || (op == OP_DATA);
  assign load_cnt = (op != OP_DATA) ? '0 :
                    (num_f == '0)   ? CNT_W'(1 << NUM_W) : {1'b0, num_f};

  assign cancel   = ctl_wr && ctl_wdata[CTL_CANCEL];
  assign stalled  = (stop_stall || cmd_err) && !cancel;
  assign idle     = (phase == PH_IDLE);
  assign data_ph  = phase[0];
  assign do_stop  = idle && !stalled && stp_req;
  assign do_rst   = idle && !stalled && !stp_req && rst_req;
  assign do_fetch = idle && !stalled && !stp_req && !rst_req && in_valid;
  assign do_data  = data_ph && !stalled && in_valid;
  assign consume  = do_fetch || do_data;
  assign last_pos = (pos == POS_W'(PKT_WORDS - 1));
  assign in_pop   = consume && last_pos;
  assign in_flush = do_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;  pos <= '0;  left <= '0;  irq_en <= 1'b0;
      stp_req <= 1'b0;   rst_req <= 1'b0;
      stop_stall <= 1'b0; cmd_err <= 1'b0; irq_seen <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; irq <= 1'b0;
    end else if (do_rst) begin
      phase <= PH_IDLE;  pos <= '0;  left <= '0;  irq_en <= 1'b0;
      stp_req <= 1'b0;   rst_req <= 1'b0;
      stop_stall <= 1'b0; cmd_err <= 1'b0; irq_seen <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; irq <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      irq <= 1'b0;
      if (cancel) begin
        stop_stall <= 1'b0;
        cmd_err <= 1'b0;
        irq_seen <= 1'b0;
      end
      if (consume) pos <= last_pos ? '0 : pos + 1'b1;
      if (do_stop) begin
        stop_stall <= 1'b1;
        stp_req <= 1'b0;
      end
      if (ctl_wr && ctl_wdata[CTL_STOP]) stp_req <= 1'b1;
      if (ctl_wr && ctl_wdata[CTL_RST])  rst_req <= 1'b1;
      if (do_fetch) begin
        if (cmd_ok) begin
          phase <= PH_DEC;
          left <= load_cnt;
          irq_en <= cur_word[IRQ_BIT];
          cmd_err <= 1'b0;
        end else begin
          cmd_err <= 1'b1;
        end
      end
      if (phase == PH_DEC) begin
        if (left == '0) begin
          phase <= PH_IDLE;
          if (irq_en) begin
            irq <= 1'b1;
            irq_seen <= 1'b1;
          end
        end else begin
          phase <= PH_XFER;
        end
      end
      if (data_ph) begin
        if (do_data) begin
          out_valid <= 1'b1;
          out_data <= cur_word;
          left <= left - 1'b1;
          if (left == CNT_W'(1)) begin
            phase <= PH_IDLE;
            if (irq_en) begin
              irq <= 1'b1;
              irq_seen <= 1'b1;
            end
          end else begin
            phase <= PH_XFER;
          end
        end else begin
          phase <= PH_WAIT;
        end
      end
    end
  end

  // R4: decode lasts exactly one cycle
  a_r4_decode_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_DEC |=> phase != PH_DEC);

  // R5: a data strobe only follows a data phase cycle
  a_r5_strobe_from_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(phase[0]));

  // R6: completion pulse only with the block back in idle
  a_r6_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> phase == PH_IDLE);

  // R2: popping the packet restarts at word 0
  a_r2_pop_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |=> pos == '0);

  // R10: stop stall only rises out of idle
  a_r10_stop_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_stall) |-> $past(phase) == PH_IDLE);

  // R11: flush only while idle
  a_r11_flush_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_flush |-> phase == PH_IDLE && !stop_stall && !cmd_err);

  // R8: a stall freezes the word position and emits nothing
  a_r8_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stall || cmd_err) && !(ctl_wr && ctl_wdata[CTL_CANCEL]) |=> $stable(pos) && !out_valid);

endmodule

// File: tb/test_pkt_cmd_parser.sv
`timescale 1ns/1ps
module test_pkt_cmd_parser;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid, in_pop, in_flush;
  logic [127:0] in_data;
  logic ctl_wr = 1'b0;
  logic [2:0] ctl_wdata = 3'b000;
  logic [1:0] phase;
  logic stop_stall, cmd_err, irq_seen, out_valid, irq;
  logic [31:0] out_data;

  always #10 clk = ~clk;

  pkt_cmd_parser i_pkt_cmd_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_pop(in_pop), .in_flush(in_flush), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .phase(phase), .stop_stall(stop_stall), .cmd_err(cmd_err), .irq_seen(irq_seen),
    .out_valid(out_valid), .out_data(out_data), .irq(irq)
  );

  logic [127:0] pk [0:127];
  logic [127:0] acc = '0;
  int acc_n = 0, wr_p = 0, rd_p = 0;
  assign in_valid = (rd_p != wr_p);
  assign in_data  = pk[rd_p % 128];

  always @(posedge clk) begin
    if (in_flush) rd_p <= wr_p;
    else if (in_pop) rd_p <= rd_p + 1;
  end

  logic [31:0] exp_d [0:1023];
  int exp_n = 0, got_n = 0, exp_irq = 0, irq_cnt = 0, dser = 0;
  int n_chk = 0, n_bad = 0, m_chk = 0, m_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        m_chk++;
        if (got_n >= exp_n || out_data !== exp_d[got_n]) begin
          m_bad++;
          $display("FAIL R5 data word %0d: actual %h expected %h", got_n, out_data,
                   (got_n < exp_n) ? exp_d[got_n] : 32'hx);
        end
        got_n++;
      end
      if (irq) irq_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] cmd_word(input logic ir, input logic [6:0] op, input logic [7:0] num);
    return {ir, op, num, 16'h0000};
  endfunction

  task automatic push_word(input logic [31:0] w);
    acc[acc_n*32 +: 32] = w;
    acc_n++;
    if (acc_n == 4) begin
      pk[wr_p % 128] = acc;
      wr_p++;
      acc_n = 0;
    end
  endtask

  task automatic push_cmd(input logic ir, input logic [6:0] op, input logic [7:0] num);
    push_word(cmd_word(ir, op, num));
    if (ir && (op == 7'd0 || op == 7'd1)) exp_irq++;
  endtask

  task automatic push_data(input int k);
    for (int i = 0; i < k; i++) begin
      logic [31:0] w;
      w = 32'hD000_0000 | 32'(dser);
      dser++;
      push_word(w);
      exp_d[exp_n] = w;
      exp_n++;
    end
  endtask

  task automatic pad();
    while (acc_n != 0) push_word(32'h0);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      if (rd_p == wr_p && acc_n == 0 && phase == 2'b00) break;
      tick();
    end
    repeat (2) tick();
  endtask

  task automatic ctl(input logic [2:0] v);
    ctl_wr = 1'b1;
    ctl_wdata = v;
    tick();
    ctl_wr = 1'b0;
    ctl_wdata = 3'b000;
  endtask

  localparam logic [15:0] VEC [8] = '{16'h8101, 16'h0103, 16'h8105, 16'h0000,
                                      16'h8000, 16'h0104, 16'h8107, 16'h0102};

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk + 1, n_bad + m_bad + 1);
    $finish;
  end

  initial begin
    int g0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(phase == 2'b00, "R1 phase after reset", 32'(phase), 0);
    chk({stop_stall, cmd_err, irq_seen} == 3'b000, "R1 flags after reset", {stop_stall, cmd_err, irq_seen}, 0);
    chk({out_valid, irq, in_pop, in_flush} == 4'b0000, "R1 strobes after reset", {out_valid, irq, in_pop, in_flush}, 0);

    // table of commands: {irq, opcode, count}
    for (int v = 0; v < 8; v++) begin
      logic [7:0] num;
      num = VEC[v][7:0];
      push_cmd(VEC[v][15], VEC[v][14:8], num);
      if (VEC[v][14:8] == 7'd1) push_data((num == 8'd0) ? 256 : int'(num));
      pad();
      drain();
      chk(got_n == exp_n, "R5 word count per vector", got_n, exp_n);
      chk(irq_cnt == exp_irq, "R6 interrupt count per vector", irq_cnt, exp_irq);
      chk(cmd_err == 1'b0, "R7 valid command leaves no error", cmd_err, 0);
    end

    // cycle-exact timing
    push_cmd(1'b1, 7'd1, 8'd2);
    push_data(2);
    push_word(32'h0);
    tick();
    chk(phase == 2'b10, "R4 decode after fetch", phase, 2);
    tick();
    chk(phase == 2'b11, "R1 transfer phase encoding", phase, 3);
    tick();
    chk(out_valid && phase == 2'b11, "R5 first word strobe", {out_valid, phase}, 3'b111);
    tick();
    chk(phase == 2'b00 && irq, "R6 pulse at completion", {phase, irq}, 3'b001);
    chk(in_pop == 1'b1, "R2 pop on word 3", in_pop, 1);
    tick();
    chk(phase == 2'b10 && !irq, "R6 single cycle pulse", {phase, irq}, 3'b100);
    chk(in_valid == 1'b0, "R2 packet removed", in_valid, 0);
    tick();
    chk(phase == 2'b00 && !irq, "R6 no pulse without bit 31", {phase, irq}, 0);

    // waiting for data
    push_cmd(1'b0, 7'd1, 8'd5);
    push_data(5);
    for (int k = 0; k < 30 && phase != 2'b01; k++) tick();
    chk(phase == 2'b01, "R3 waiting phase encoding", phase, 1);
    tick();
    chk(phase == 2'b01 && !out_valid, "R3 no progress without packet", {phase, out_valid}, 3'b010);
    pad();
    drain();
    chk(got_n == exp_n, "R3 words after refill", got_n, exp_n);

    // partial packet is not used
    push_cmd(1'b0, 7'd1, 8'd1);
    repeat (3) tick();
    chk(phase == 2'b00 && !in_pop, "R3 partial packet ignored", {phase, in_pop}, 0);
    push_data(1);
    pad();
    drain();
    chk(got_n == exp_n, "R3 words after completion", got_n, exp_n);

    // invalid command, stall, cancel with same-cycle fetch
    push_word(cmd_word(1'b1, 7'h05, 8'd3));
    push_cmd(1'b0, 7'd1, 8'd1);
    push_data(1);
    push_word(32'h0);
    tick();
    chk(cmd_err && phase == 2'b00, "R7 error on bad opcode", {cmd_err, phase}, 3'b100);
    g0 = got_n;
    repeat (3) tick();
    chk(cmd_err && phase == 2'b00 && got_n == g0, "R8 error stall holds", {cmd_err, phase}, 3'b100);
    chk(irq_seen == 1'b1, "R6 sticky flag set", irq_seen, 1);
    ctl(3'b100);
    chk(!cmd_err && phase == 2'b10, "R9 cancel and fetch same cycle", {cmd_err, phase}, 3'b010);
    chk(irq_seen == 1'b0, "R9 cancel clears sticky flag", irq_seen, 0);
    drain();
    chk(got_n == exp_n, "R7 next command runs", got_n, exp_n);
    chk(irq_cnt == exp_irq, "R7 bad command raises nothing", irq_cnt, exp_irq);

    // stop request during a transfer
    push_cmd(1'b0, 7'd1, 8'd6);
    push_data(6);
    pad();
    tick();
    ctl(3'b010);
    for (int k = 0; k < 30 && phase != 2'b00; k++) tick();
    chk(phase == 2'b00 && !stop_stall, "R10 stop waits for idle", {phase, stop_stall}, 0);
    tick();
    chk(stop_stall && phase == 2'b00, "R10 stop taken in idle", {stop_stall, phase}, 3'b100);
    repeat (4) tick();
    chk(stop_stall && in_valid, "R8 stop stall blocks fetch", {stop_stall, in_valid}, 2'b11);
    ctl(3'b100);
    drain();
    chk(!stop_stall, "R10 request self-cleared", stop_stall, 0);
    chk(got_n == exp_n, "R10 data intact", got_n, exp_n);

    // reset request
    push_cmd(1'b0, 7'd1, 8'd1);
    push_data(1);
    push_word(32'h0);
    push_word(cmd_word(1'b0, 7'd1, 8'd8));
    for (int i = 0; i < 4; i++) push_word(32'hBAD0_0000 | 32'(i));
    ctl(3'b001);
    chk(phase == 2'b10, "R11 fetch before reset taken", phase, 2);
    tick();
    tick();
    chk(phase == 2'b00 && in_flush, "R11 flush pulse in idle", {phase, in_flush}, 1);
    tick();
    chk(!in_valid && phase == 2'b00 && !in_flush, "R11 FIFO emptied", {in_valid, phase, in_flush}, 0);
    push_cmd(1'b1, 7'd1, 8'd1);
    push_data(1);
    pad();
    drain();
    chk(got_n == exp_n, "R11 parse restarts at word 0", got_n, exp_n);
    chk(irq_cnt == exp_irq, "R11 interrupt after reset", irq_cnt, exp_irq);

    // count field of zero means 256
    push_cmd(1'b0, 7'd1, 8'd0);
    push_data(256);
    pad();
    drain();
    chk(got_n == exp_n, "R4 zero count gives 256 words", got_n, exp_n);
    chk(irq_cnt == exp_irq, "R6 no pulse for long command", irq_cnt, exp_irq);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + m_chk, n_bad + m_bad);
    $finish;
  end

endmodule